// File: doc/BRIEF.md
# Arbitrary-Ratio Stream Width Converter

This block repacks a valid/ready stream of `IN_W`-bit words into a stream of `OUT_W`-bit words. No bit is lost, duplicated or reordered. Either width may be the larger one, and neither has to divide the other. The bit stream is read least significant bit first: bit 0 of the first input word is the first bit of the stream, and it comes out as bit 0 of the first output word.

When the wider of the two widths is an exact multiple of the narrower one, a single integer-ratio stage does the work. The stage widens, narrows or simply registers the data. When the ratio is not an integer (for example 6 to 4 or 4 to 6 bits), the block chains two integer-ratio stages. The first widens `IN_W` to `LCM_W = lcm(IN_W, OUT_W)`. The second narrows `LCM_W` to `OUT_W`.

Data is grouped into frames of `NUM_IN_WORDS` input words, and frames follow each other back to back. For a non-integer ratio, `NUM_IN_WORDS` must be a multiple of `LCM_W / IN_W`. If it is not, elaboration stops with an error. The intermediate stream then carries `NUM_IN_WORDS / (LCM_W / IN_W)` words per frame.

Top module: `dwc_repacker`

## Requirements
- R1: The output words, concatenated least significant bit first, reproduce the concatenated input bit sequence exactly, apart from the frame padding of R6.
- R2: In a widening conversion, the first narrow word accepted goes into bits [IN_W-1:0] of the wide word. Each later word goes into the next higher slice. A wide word is offered once OUT_W/IN_W narrow words have been accepted.
- R3: In a narrowing conversion, each accepted wide word is emitted as IN_W/OUT_W output words, starting with bits [OUT_W-1:0] and moving toward the most significant slice.
- R4: Width pairs whose larger width is not a multiple of the smaller one pass through an intermediate stream of LCM_W bits. The 6-to-4 and 4-to-6 conversions both preserve every bit.
- R5: With IN_W equal to OUT_W, each input word appears unchanged as one output word.
- R6: In a direct widening conversion where NUM_IN_WORDS is not a multiple of OUT_W/IN_W, the last input word of a frame closes the current wide word. Its unfilled upper slices read as zero, and the next frame starts a fresh wide word.
- R7: While out_vld is high and out_rdy is low, out_vld stays high and out_data does not change. Every bit is delivered exactly once under any back-pressure pattern. When out_vld is low, in_rdy is high.
- R8: While rst_n is low and right after its release, out_vld is low and in_rdy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Input word valid |
| in_rdy | output | 1 | Block accepts the input word this cycle |
| in_data | input | IN_W | Input word |
| out_vld | output | 1 | Output word valid |
| out_rdy | input | 1 | Downstream accepts the output word this cycle |
| out_data | output | OUT_W | Output word |

## Verification
An input word can be accepted in the same cycle that a finished output word leaves. For a narrowing stage, a new wide word can load in the very cycle its last slice departs. In a widening stage with a short frame, the frame-closing input word can arrive while the previous wide word is still being taken.

The bench provokes these collisions by holding out_rdy high during the first third of each run while input words arrive almost every cycle. It then mixes in long and random stalls. Every accepted output word is compared with the bits popped from a reference bit queue, which is filled from the input handshakes plus the frame padding computed in a bench function. At the end the queue must be empty, so a dropped or duplicated slice shows up as a mismatch or as leftover bits.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  typedef enum logic [1:0] {
    DWC_PASS = 2'd0,
    DWC_UP   = 2'd1,
    DWC_DOWN = 2'd2
  } dwc_kind_e;

  function automatic int gcd_f(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcm_f(input int a, input int b);
    return (a / gcd_f(a, b)) * b;
  endfunction

  function automatic dwc_kind_e kind_f(input int iw, input int ow);
    if (iw == ow) return DWC_PASS;
    else if (ow > iw) return DWC_UP;
    else return DWC_DOWN;
  endfunction

endpackage

// File: rtl/dwc_up_stage.sv
module dwc_up_stage #(
  parameter int IN_W        = 2,
  parameter int OUT_W       = 8,
  parameter int FRAME_WORDS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  output logic             in_rdy,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_vld,
  input  logic             out_rdy,
  output logic [OUT_W-1:0] out_data
);
  localparam int RATIO = OUT_W / IN_W;
  localparam int CW    = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int FCW   = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;

  logic [OUT_W-1:0] acc_q, acc_d, dat_q, merged;
  logic [CW-1:0]    slot_q, slot_d;
  logic [FCW-1:0]   word_q, word_d;
  logic             vld_q, vld_d;
  logic             take, frame_end, close_word, dat_en;

  always_comb begin
    in_rdy     = !vld_q || out_rdy;
    take       = in_vld && in_rdy;
    frame_end  = (word_q == FCW'(FRAME_WORDS - 1));
    close_word = (slot_q == CW'(RATIO - 1)) || frame_end;
    merged     = acc_q | (OUT_W'(in_data) << (int'(slot_q) * IN_W));
    acc_d      = acc_q;
    slot_d     = slot_q;
    word_d     = word_q;
    vld_d      = vld_q && !out_rdy;
    dat_en     = 1'b0;
    if (take) begin
      word_d = frame_end ? '0 : word_q + FCW'(1);
      if (close_word) begin
        acc_d  = '0;
        slot_d = '0;
        vld_d  = 1'b1;
        dat_en = 1'b1;
      end else begin
        acc_d  = merged;
        slot_d = slot_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      slot_q <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (take) begin
        acc_q  <= acc_d;
        slot_q <= slot_d;
        word_q <= word_d;
      end
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= merged;
  end

  assign out_vld  = vld_q;
  assign out_data = dat_q;
endmodule

// File: rtl/dwc_down_stage.sv
module dwc_down_stage #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  output logic             in_rdy,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_vld,
  input  logic             out_rdy,
  output logic [OUT_W-1:0] out_data
);
  localparam int RATIO = IN_W / OUT_W;
  localparam int CW    = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [IN_W-1:0] hold_q;
  logic [CW-1:0]   slot_q, slot_d;
  logic            full_q, full_d;
  logic            last, pop, take;

  always_comb begin
    last   = (slot_q == CW'(RATIO - 1));
    pop    = full_q && out_rdy;
    in_rdy = !full_q || (out_rdy && last);
    take   = in_vld && in_rdy;
    slot_d = slot_q;
    if (pop) slot_d = last ? '0 : slot_q + CW'(1);
    full_d = full_q;
    if (pop && last) full_d = 1'b0;
    if (take)        full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (pop) slot_q <= slot_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (take) hold_q <= in_data;
  end

  assign out_vld  = full_q;
  assign out_data = hold_q[int'(slot_q) * OUT_W +: OUT_W];
endmodule

// File: rtl/dwc_pass_stage.sv
module dwc_pass_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  output logic         in_rdy,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  input  logic         out_rdy,
  output logic [W-1:0] out_data
);
  logic [W-1:0] dat_q;
  logic         vld_q, vld_d, take;

  always_comb begin
    in_rdy = !vld_q || out_rdy;
    take   = in_vld && in_rdy;
    vld_d  = take || (vld_q && !out_rdy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (take) dat_q <= in_data;
    end
  end

  assign out_vld  = vld_q;
  assign out_data = dat_q;
endmodule

// File: rtl/dwc_link.sv
module dwc_link
  import dwc_pkg::*;
#(
  parameter int IN_W        = 2,
  parameter int OUT_W       = 4,
  parameter int FRAME_WORDS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  output logic             in_rdy,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_vld,
  input  logic             out_rdy,
  output logic [OUT_W-1:0] out_data
);
  localparam dwc_kind_e KIND = kind_f(IN_W, OUT_W);

  if (FRAME_WORDS < 1) begin : g_bad_frame
    $error("dwc_link: frame word count must be at least one");
  end

  if (KIND == DWC_PASS) begin : g_pass
    dwc_pass_stage #(.W(IN_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_vld(in_vld), .in_rdy(in_rdy), .in_data(in_data),
      .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data)
    );
  end else if (KIND == DWC_UP) begin : g_up
    dwc_up_stage #(.IN_W(IN_W), .OUT_W(OUT_W), .FRAME_WORDS(FRAME_WORDS)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_vld(in_vld), .in_rdy(in_rdy), .in_data(in_data),
      .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data)
    );
  end else begin : g_down
    dwc_down_stage #(.IN_W(IN_W), .OUT_W(OUT_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_vld(in_vld), .in_rdy(in_rdy), .in_data(in_data),
      .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data)
    );
  end
endmodule

// File: rtl/dwc_repacker.sv
module dwc_repacker
  import dwc_pkg::*;
#(
  parameter int IN_W         = 6,
  parameter int OUT_W        = 4,
  parameter int NUM_IN_WORDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  output logic             in_rdy,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_vld,
  input  logic             out_rdy,
  output logic [OUT_W-1:0] out_data
);
  localparam int MAX_W     = (IN_W > OUT_W) ? IN_W : OUT_W;
  localparam int MIN_W     = (IN_W > OUT_W) ? OUT_W : IN_W;
  localparam bit DIRECT    = (MAX_W % MIN_W) == 0;
  localparam int LCM_W     = lcm_f(IN_W, OUT_W);
  localparam int PER_LCM   = LCM_W / IN_W;
  localparam int LCM_WORDS = NUM_IN_WORDS / PER_LCM;

  if (DIRECT) begin : g_direct
    dwc_link #(.IN_W(IN_W), .OUT_W(OUT_W), .FRAME_WORDS(NUM_IN_WORDS)) u_only (
      .clk(clk), .rst_n(rst_n),
      .in_vld(in_vld), .in_rdy(in_rdy), .in_data(in_data),
      .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data)
    );
  end else begin : g_cascade
    if ((NUM_IN_WORDS % PER_LCM) != 0) begin : g_bad_count
      $error("dwc_repacker: input words per frame not a multiple of LCM_W/IN_W");
    end

    logic             mid_vld, mid_rdy;
    logic [LCM_W-1:0] mid_data;

    dwc_link #(.IN_W(IN_W), .OUT_W(LCM_W), .FRAME_WORDS(NUM_IN_WORDS)) u_widen (
      .clk(clk), .rst_n(rst_n),
      .in_vld(in_vld), .in_rdy(in_rdy), .in_data(in_data),
      .out_vld(mid_vld), .out_rdy(mid_rdy), .out_data(mid_data)
    );

    dwc_link #(.IN_W(LCM_W), .OUT_W(OUT_W), .FRAME_WORDS(LCM_WORDS)) u_narrow (
      .clk(clk), .rst_n(rst_n),
      .in_vld(mid_vld), .in_rdy(mid_rdy), .in_data(mid_data),
      .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data)
    );
  end
endmodule

// File: rtl/dwc_repacker_chk.sv
module dwc_repacker_chk #(
  parameter int OUT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_vld,
  input logic             in_rdy,
  input logic             out_vld,
  input logic             out_rdy,
  input logic [OUT_W-1:0] out_data
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seen_q <= 1'b0;
    else if (in_vld && in_rdy) seen_q <= 1'b1;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_rdy |=> out_vld && $stable(out_data)); // R7

  AST_ACCEPT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> in_rdy); // R7

  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !out_vld); // R8

  AST_NO_OUT_BEFORE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> seen_q); // R1

  AST_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> !$isunknown(out_data)); // R1
endmodule

bind dwc_repacker dwc_repacker_chk #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/tb_dwc_repacker.sv
module tb_dwc_lane #(
  parameter int          IW     = 6,
  parameter int          OW     = 4,
  parameter int          NW     = 8,
  parameter int          FRAMES = 12,
  parameter int unsigned SEED   = 1,
  parameter string       TAG    = "R1"
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  logic          in_vld, in_rdy, out_vld, out_rdy;
  logic [IW-1:0] in_data;
  logic [OW-1:0] out_data;
  int            n_chk;
  int            n_fail;
  bit            q[$];

  dwc_repacker #(.IN_W(IW), .OUT_W(OW), .NUM_IN_WORDS(NW)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_rdy(in_rdy), .in_data(in_data),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data)
  );

  // zero bits that close each frame (R6); zero unless widening leaves a partial word
  function automatic int pad_bits();
    return (OW - ((NW * IW) % OW)) % OW;
  endfunction

  function automatic logic [IW-1:0] pick_word(input int idx);
    if (idx == 0) return '1;
    if (idx == 1) return '0;
    return IW'($urandom);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s (%0d->%0d): actual %0h expected %0h", req, what, IW, OW, act, exp);
    end
  endtask

  initial begin
    int          total;
    int          sent;
    int          wif;
    int          idle;
    bit          pend;
    int unsigned seed_dummy;
    logic [OW-1:0] exp_w;
    done    = 1'b0;
    in_vld  = 1'b0;
    in_data = '0;
    out_rdy = 1'b0;
    n_chk   = 0;
    n_fail  = 0;
    total   = FRAMES * NW;
    sent    = 0;
    wif     = 0;
    idle    = 0;
    pend    = 1'b0;
    seed_dummy = $urandom(SEED);
    @(posedge rst_n);
    @(negedge clk);
    #1;
    check(!out_vld, "R8", "out_vld after reset", longint'(out_vld), 0);
    check(in_rdy, "R8", "in_rdy after reset", longint'(in_rdy), 1);
    while (!(sent == total && !pend && q.size() == 0) && idle < 3000) begin
      @(negedge clk);
      if (sent >= total)          out_rdy = 1'b1;
      else if (sent < total / 3)  out_rdy = 1'b1;
      else if (sent < 2 * total / 3) out_rdy = ($urandom % 4) == 0;
      else                        out_rdy = ($urandom % 2) == 0;
      if (!pend) begin
        in_vld = 1'b0;
        if (sent < total && (sent < total / 3 || ($urandom % 4) != 0)) begin
          in_data = pick_word(sent);
          in_vld  = 1'b1;
          pend    = 1'b1;
        end
      end
      #1;
      if (in_vld && in_rdy) begin
        for (int b = 0; b < IW; b++) q.push_back(in_data[b]);
        sent++;
        wif++;
        pend = 1'b0;
        if (wif == NW) begin
          for (int b = 0; b < pad_bits(); b++) q.push_back(1'b0);
          wif = 0;
        end
      end
      if (out_vld && out_rdy) begin
        idle = 0;
        if (q.size() < OW) begin
          check(1'b0, "R7", "output word without enough input bits", longint'(out_data), 0);
        end else begin
          for (int b = 0; b < OW; b++) exp_w[b] = q.pop_front();
          check(out_data == exp_w, TAG, "output word", longint'(out_data), longint'(exp_w));
        end
      end else begin
        idle++;
      end
    end
    @(negedge clk);
    in_vld = 1'b0;
    check(q.size() == 0, "R7", "bits left undelivered", q.size(), 0);
    check(sent == total, "R7", "input words accepted", sent, total);
    done = 1'b1;
  end
endmodule

module tb_dwc_repacker;
  logic clk;
  logic rst_n;
  logic d0, d1, d2, d3, d4, d5, d6;
  bit   wd;
  int   n_chk;
  int   n_fail;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // R4 cascade through LCM width, both directions
  tb_dwc_lane #(.IW(6),  .OW(4),  .NW(8), .FRAMES(12), .SEED(11), .TAG("R1 R4")) dut_l0 (.clk(clk), .rst_n(rst_n), .done(d0));
  tb_dwc_lane #(.IW(4),  .OW(6),  .NW(6), .FRAMES(12), .SEED(23), .TAG("R1 R4")) dut_l1 (.clk(clk), .rst_n(rst_n), .done(d1));
  // R6 short frame closes a partial wide word
  tb_dwc_lane #(.IW(2),  .OW(8),  .NW(3), .FRAMES(20), .SEED(37), .TAG("R2 R6")) dut_l2 (.clk(clk), .rst_n(rst_n), .done(d2));
  // R2 widening, R3 narrowing, R5 equal widths
  tb_dwc_lane #(.IW(2),  .OW(4),  .NW(4), .FRAMES(15), .SEED(41), .TAG("R1 R2")) dut_l3 (.clk(clk), .rst_n(rst_n), .done(d3));
  tb_dwc_lane #(.IW(16), .OW(4),  .NW(4), .FRAMES(10), .SEED(53), .TAG("R1 R3")) dut_l4 (.clk(clk), .rst_n(rst_n), .done(d4));
  tb_dwc_lane #(.IW(8),  .OW(8),  .NW(5), .FRAMES(12), .SEED(67), .TAG("R1 R5")) dut_l5 (.clk(clk), .rst_n(rst_n), .done(d5));
  tb_dwc_lane #(.IW(4),  .OW(2),  .NW(4), .FRAMES(12), .SEED(71), .TAG("R1 R3")) dut_l6 (.clk(clk), .rst_n(rst_n), .done(d6));

  // the main instance required by naming: default configuration
  logic          m_in_rdy, m_out_vld;
  logic [3:0]    m_out_data;
  dwc_repacker dut (
    .clk(clk), .rst_n(rst_n),
    .in_vld(1'b0), .in_rdy(m_in_rdy), .in_data(6'd0),
    .out_vld(m_out_vld), .out_rdy(1'b1), .out_data(m_out_data)
  );

  initial begin
    rst_n  = 1'b0;
    wd     = 1'b0;
    n_chk  = 0;
    n_fail = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        wait (d0 && d1 && d2 && d3 && d4 && d5 && d6);
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    @(negedge clk);
    n_chk++;
    if (m_out_vld !== 1'b0 || m_in_rdy !== 1'b1) begin
      n_fail++;
      $display("FAIL R8 idle default instance: actual vld=%0b rdy=%0b expected vld=0 rdy=1",
               m_out_vld, m_in_rdy);
    end
    n_chk  += dut_l0.n_chk + dut_l1.n_chk + dut_l2.n_chk + dut_l3.n_chk
            + dut_l4.n_chk + dut_l5.n_chk + dut_l6.n_chk;
    n_fail += dut_l0.n_fail + dut_l1.n_fail + dut_l2.n_fail + dut_l3.n_fail
            + dut_l4.n_fail + dut_l5.n_fail + dut_l6.n_fail;
    if (wd) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog expired: actual running expected all lanes done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule